// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block is the output stage that sits behind the compare logic of an 8-bit timer. It holds one internal compare-output flip-flop. That flip-flop changes on a compare-match pulse, on a software force strobe, or, in fast PWM, at the counter's bottom. A 2-bit output-action field sets how it changes. The field is held in a small register that software writes through a write-enable and a data input.

The same field decides who drives a general-purpose pin. When the field is non-zero, the pin's drive value comes from the compare flip-flop. When the field is zero, the pin's drive value comes from the port data bit. The pin's output enable always follows the port direction bit. Software can therefore set the flip-flop to a known level, with a force strobe, before it turns the pin into an output.

The counter, the compare register and the buffering of the compare value are outside this block. They appear here only as pulse inputs: match, bottom and count direction.

Top module: `tco_pin_unit`

## Requirements
- R1: After reset, the compare flip-flop is 0 and the action field is 00. The pin therefore shows `port_data`.
- R2: While the action field is 00, the compare flip-flop does not change. This holds for a match, a force or a bottom pulse, in every waveform mode.
- R3: `pin_out` equals the compare flip-flop whenever the action field is non-zero, and equals `port_data` whenever it is 00. The waveform mode does not affect this choice.
- R4: `pin_oe` always equals `port_dir`.
- R5: A write (`cfg_we`=1) loads `cfg_mode` at the clock edge. A match in the cycle that holds the write still uses the old field. A match in the next cycle uses the new field.
- R6: Waveform modes 00 (normal) and 01 (clear-on-match) are the non-PWM modes. In these modes a match or a force acts as follows: field 01 toggles the flip-flop, 10 clears it, and 11 sets it.
- R7: Waveform mode 10 is fast PWM. Field 10 clears the flip-flop on a match and sets it on a bottom pulse. Field 11 does the reverse. If a match and a bottom pulse arrive in the same cycle, the match wins.
- R8: Waveform mode 11 is phase-correct PWM. Field 10 clears the flip-flop on a match while counting up (`count_down`=0) and sets it on a match while counting down. Field 11 does the reverse. Bottom pulses are ignored in this mode.
- R9: In either PWM mode, field 01 is reserved and leaves the flip-flop unchanged.
- R10: In either PWM mode, the force strobe has no effect.
- R11: Changing the waveform mode alone leaves the flip-flop unchanged.
- R12: In a non-PWM mode, a match and a force in the same cycle produce a single action. With field 01, this means one toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the action field |
| cfg_mode | input | 2 | New action field value |
| wave_mode | input | 2 | 00 normal, 01 clear-on-match, 10 fast PWM, 11 phase-correct PWM |
| match_pulse | input | 1 | One-cycle compare-match pulse |
| force_strobe | input | 1 | One-cycle software force strobe |
| bottom_pulse | input | 1 | One-cycle pulse when the counter is at bottom |
| count_down | input | 1 | 1 while the counter counts down |
| port_data | input | 1 | Port data register bit |
| port_dir | input | 1 | Port direction bit, 1 means output |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The flip-flop cannot be read directly, so its state is observed through `pin_out`, with the action field set non-zero. Several stimulus patterns are used, and each one separates a different class of fault:
- Toggle sequences with match and force arriving alone and together show whether one event gives exactly one action.
- Fast PWM runs with match and bottom pulses, including both in the same cycle, separate the set path from the clear path.
- Phase-correct runs with both count directions show whether the direction is honoured, and whether bottom pulses are correctly ignored.
- A match placed in the write cycle and another in the cycle after it show whether the new field applies without delay or one cycle early.
- Random mixes of all inputs then compare pin value and enable against a bench model on every cycle.

// File: rtl/tco_pkg.sv
package tco_pkg;
  localparam int unsigned FIELD_W = 2;
  localparam int unsigned WAVE_W  = 2;

  typedef enum logic [WAVE_W-1:0] {
    WV_NORMAL = 2'b00,
    WV_CLRMT  = 2'b01,
    WV_FAST   = 2'b10,
    WV_PHASE  = 2'b11
  } wave_e;

  typedef enum logic [FIELD_W-1:0] {
    FA_OFF    = 2'b00,
    FA_TOGGLE = 2'b01,
    FA_CLEAR  = 2'b10,
    FA_SET    = 2'b11
  } field_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_SET,
    ACT_CLR,
    ACT_TGL
  } act_e;

  function automatic logic is_pwm(input logic [WAVE_W-1:0] w);
    return w[WAVE_W-1];
  endfunction

  // Level the flip-flop takes on the "primary" event of a PWM mode
  // (match in fast PWM, up-count match in phase-correct PWM).
  function automatic logic primary_level(input logic [FIELD_W-1:0] f);
    return (f == FA_SET);
  endfunction

  function automatic act_e level_act(input logic lvl);
    return lvl ? ACT_SET : ACT_CLR;
  endfunction

  function automatic act_e decide(
    input logic [FIELD_W-1:0] f,
    input logic [WAVE_W-1:0]  w,
    input logic mt,
    input logic fo,
    input logic bo,
    input logic dn
  );
    act_e a;
    a = ACT_NONE;
    if (f != FA_OFF) begin
      if (!is_pwm(w)) begin
        if (mt || fo) begin
          unique case (f)
            FA_TOGGLE: a = ACT_TGL;
            FA_CLEAR:  a = ACT_CLR;
            default:   a = ACT_SET;
          endcase
        end
      end else if (f != FA_TOGGLE) begin
        if (w == WV_FAST) begin
          if (mt)      a = level_act(primary_level(f));
          else if (bo) a = level_act(!primary_level(f));
        end else begin
          if (mt)      a = level_act(dn ? !primary_level(f) : primary_level(f));
        end
      end
    end
    return a;
  endfunction
endpackage

// File: rtl/tco_field_reg.sv
module tco_field_reg
  import tco_pkg::*;
#(
  parameter int unsigned W = FIELD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] field_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  field_q <= '0;
    else if (we) field_q <= wdata;
  end

  // R5: a written value is in place one clock later
  a_r5_field_next: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (field_q == $past(wdata)));
endmodule

// File: rtl/tco_action_dec.sv
module tco_action_dec
  import tco_pkg::*;
(
  input  logic [FIELD_W-1:0] field_q,
  input  logic [WAVE_W-1:0]  wave_mode,
  input  logic               match_pulse,
  input  logic               force_strobe,
  input  logic               bottom_pulse,
  input  logic               count_down,
  output logic               evt_set,
  output logic               evt_clr,
  output logic               evt_tgl
);
  act_e act;

  always_comb begin
    act     = decide(field_q, wave_mode, match_pulse, force_strobe,
                     bottom_pulse, count_down);
    evt_set = (act == ACT_SET);
    evt_clr = (act == ACT_CLR);
    evt_tgl = (act == ACT_TGL);
  end
endmodule

// File: rtl/tco_cmp_ff.sv
module tco_cmp_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_set,
  input  logic evt_clr,
  input  logic evt_tgl,
  output logic cmp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_q <= 1'b0;
    else if (evt_set) cmp_q <= 1'b1;
    else if (evt_clr) cmp_q <= 1'b0;
    else if (evt_tgl) cmp_q <= ~cmp_q;
  end

  // R6: a toggle event flips the stored level exactly once
  a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tgl |=> (cmp_q != $past(cmp_q)));
  // R11: with no event the level holds
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_set || evt_clr || evt_tgl) |=> $stable(cmp_q));
endmodule

// File: rtl/tco_pin_mux.sv
module tco_pin_mux
  import tco_pkg::*;
(
  input  logic [FIELD_W-1:0] field_q,
  input  logic               cmp_q,
  input  logic               port_data,
  input  logic               port_dir,
  output logic               pin_out,
  output logic               pin_oe
);
  logic override;

  always_comb begin
    override = |field_q;
    pin_out  = override ? cmp_q : port_data;
    pin_oe   = port_dir;
  end
endmodule

// File: rtl/tco_pin_unit.sv
module tco_pin_unit
  import tco_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [FIELD_W-1:0] cfg_mode,
  input  logic [WAVE_W-1:0]  wave_mode,
  input  logic               match_pulse,
  input  logic               force_strobe,
  input  logic               bottom_pulse,
  input  logic               count_down,
  input  logic               port_data,
  input  logic               port_dir,
  output logic               pin_out,
  output logic               pin_oe
);
  logic [FIELD_W-1:0] field_q;
  logic evt_set, evt_clr, evt_tgl;
  logic cmp_q;

  tco_field_reg #(.W(FIELD_W)) u_field (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_mode), .field_q(field_q)
  );

  tco_action_dec u_dec (
    .field_q(field_q), .wave_mode(wave_mode), .match_pulse(match_pulse),
    .force_strobe(force_strobe), .bottom_pulse(bottom_pulse),
    .count_down(count_down), .evt_set(evt_set), .evt_clr(evt_clr),
    .evt_tgl(evt_tgl)
  );

  tco_cmp_ff u_ff (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
    .evt_tgl(evt_tgl), .cmp_q(cmp_q)
  );

  tco_pin_mux u_mux (
    .field_q(field_q), .cmp_q(cmp_q), .port_data(port_data),
    .port_dir(port_dir), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R2: field 00 freezes the flip-flop
  a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q == 2'b00) |=> $stable(cmp_q));
  // R9: reserved field in PWM modes does nothing
  a_r9_reserved_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode[1] && field_q == 2'b01) |=> $stable(cmp_q));
  // R10: force alone in PWM modes does nothing
  a_r10_force_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode[1] && force_strobe && !match_pulse && !bottom_pulse)
      |=> $stable(cmp_q));
  // R12: at most one action per cycle
  a_r12_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_set, evt_clr, evt_tgl}));
endmodule

// File: tb/tco_pin_unit_tb.sv
`timescale 1ns/1ps
module tco_pin_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_mode, wave_mode;
  logic match_pulse, force_strobe, bottom_pulse, count_down;
  logic port_data, port_dir;
  logic pin_out, pin_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic m_ff, m_fld;
  logic [1:0] m_field;

  always #10 clk = ~clk;

  tco_pin_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .wave_mode(wave_mode), .match_pulse(match_pulse),
    .force_strobe(force_strobe), .bottom_pulse(bottom_pulse),
    .count_down(count_down), .port_data(port_data), .port_dir(port_dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Bench model of the flip-flop's next level, arranged by waveform mode first.
  function automatic logic model_next(logic cur, logic [1:0] fld, logic [1:0] wv,
                                      logic mt, logic fo, logic bo, logic dn);
    if (fld == 2'b00) return cur;
    case (wv)
      2'b00, 2'b01: begin
        if (!(mt || fo)) return cur;
        if (fld == 2'b01) return !cur;
        return fld[0];
      end
      2'b10: begin
        if (fld == 2'b01) return cur;
        if (mt) return (fld == 2'b11);
        if (bo) return (fld == 2'b10);
        return cur;
      end
      default: begin
        if (fld == 2'b01 || !mt) return cur;
        return dn ? (fld == 2'b10) : (fld == 2'b11);
      end
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_pins(string tag);
    check(tag, pin_out, (m_field != 2'b00) ? m_ff : port_data);
    check("R4", pin_oe, port_dir);
  endtask

  // Drive one cycle of stimulus, advance the model, land 2 ns after the edge.
  task automatic cyc(logic we, logic [1:0] fv, logic [1:0] wv,
                     logic mt, logic fo, logic bo, logic dn);
    cfg_we = we; cfg_mode = fv; wave_mode = wv;
    match_pulse = mt; force_strobe = fo; bottom_pulse = bo; count_down = dn;
    m_fld = model_next(m_ff, m_field, wv, mt, fo, bo, dn);
    @(posedge clk);
    #2;
    m_ff = m_fld;
    if (we) m_field = fv;
    cfg_we = 0; match_pulse = 0; force_strobe = 0; bottom_pulse = 0;
  endtask

  task automatic set_field(logic [1:0] f, logic [1:0] wv);
    cyc(1, f, wv, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cfg_we = 0; cfg_mode = 0; wave_mode = 0;
    match_pulse = 0; force_strobe = 0; bottom_pulse = 0; count_down = 0;
    port_data = 1; port_dir = 0;
    m_ff = 0; m_field = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    check("R1", pin_out, 1'b1);
    port_data = 0; #1;
    check("R1", pin_out, 1'b0);
    check("R4", pin_oe, 1'b0);
    port_dir = 1; #1;
    check("R4", pin_oe, 1'b1);

    // R2: field 00 ignores events in all waveform modes
    for (int w = 0; w < 4; w++) cyc(0, 0, w[1:0], 1, 1, 1, w[0]);
    set_field(2'b01, 2'b00);
    check("R2", pin_out, 1'b0);

    // R6 toggle via match, then via force (force sets level before pin use)
    cyc(0, 0, 2'b00, 1, 0, 0, 0); check("R6", pin_out, 1'b1);
    cyc(0, 0, 2'b01, 0, 1, 0, 0); check("R6", pin_out, 1'b0);
    // R12 match and force together toggle once
    cyc(0, 0, 2'b00, 1, 1, 0, 0); check("R12", pin_out, 1'b1);
    // R6 clear and set
    set_field(2'b10, 2'b00); cyc(0, 0, 2'b00, 0, 1, 0, 0); check("R6", pin_out, 1'b0);
    set_field(2'b11, 2'b00); cyc(0, 0, 2'b01, 1, 0, 0, 0); check("R6", pin_out, 1'b1);

    // R5: match in write cycle uses old field (11 -> stays 1), next uses new (10 -> 0)
    cyc(1, 2'b10, 2'b00, 1, 0, 0, 0); check("R5", pin_out, 1'b1);
    cyc(0, 0, 2'b00, 1, 0, 0, 0);     check("R5", pin_out, 1'b0);

    // R11: waveform changes alone keep the level
    set_field(2'b11, 2'b00); cyc(0, 0, 2'b00, 1, 0, 0, 0);
    cyc(0, 0, 2'b10, 0, 0, 0, 0); cyc(0, 0, 2'b11, 0, 0, 0, 1);
    check("R11", pin_out, 1'b1);

    // R7 fast PWM
    set_field(2'b10, 2'b10);
    cyc(0, 0, 2'b10, 1, 0, 0, 0); check("R7", pin_out, 1'b0);
    cyc(0, 0, 2'b10, 0, 0, 1, 0); check("R7", pin_out, 1'b1);
    cyc(0, 0, 2'b10, 1, 0, 1, 0); check("R7", pin_out, 1'b0);
    set_field(2'b11, 2'b10);
    cyc(0, 0, 2'b10, 1, 0, 0, 0); check("R7", pin_out, 1'b1);
    // R10 force ignored in PWM
    set_field(2'b10, 2'b10);
    cyc(0, 0, 2'b10, 0, 1, 0, 0); check("R10", pin_out, 1'b1);
    cyc(0, 0, 2'b11, 0, 1, 0, 1); check("R10", pin_out, 1'b1);

    // R8 phase-correct
    cyc(0, 0, 2'b11, 1, 0, 0, 0); check("R8", pin_out, 1'b0);
    cyc(0, 0, 2'b11, 1, 0, 0, 1); check("R8", pin_out, 1'b1);
    cyc(0, 0, 2'b11, 0, 0, 1, 0); check("R8", pin_out, 1'b1);
    set_field(2'b11, 2'b11);
    cyc(0, 0, 2'b11, 1, 0, 0, 1); check("R8", pin_out, 1'b0);

    // R9 reserved field in PWM
    set_field(2'b01, 2'b11);
    cyc(0, 0, 2'b11, 1, 1, 1, 0); check("R9", pin_out, 1'b0);
    cyc(0, 0, 2'b10, 1, 1, 1, 0); check("R9", pin_out, 1'b0);

    // R3: override choice does not depend on waveform mode
    port_data = 1;
    for (int w = 0; w < 4; w++) begin
      wave_mode = w[1:0]; #1; check("R3", pin_out, 1'b0);
    end
    set_field(2'b00, 2'b10); check("R3", pin_out, 1'b1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      port_data = 1'($urandom); port_dir = 1'($urandom);
      cyc(($urandom % 8) == 0, 2'($urandom), 2'($urandom),
          1'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom));
      check_pins("R3");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule